// File: doc/BRIEF.md
# Host Word Handshake Engine

This block is the remote-host side of a DMA word path. For each word that the local transfer sequencer hands it, the block raises a cycle request towards a remote DMA interface. It waits for that interface to report busy, withdraws the request, and waits for busy to fall again. That fall marks the end of the host cycle, and the block then pulses a one-cycle completion flag back to the sequencer. The sequencer uses that flag to write the captured word into memory (host-to-memory) or to fetch the next word (memory-to-host).

The active level of the request pin and of the busy pin can each be chosen at run time, so all four pairings are covered. All host inputs pass through two-flop synchronizers before their polarity is corrected. A high level on the host's second function-code line acts as an abort. It returns the engine to idle, drops any pending word and latches an interrupt flag. The same synchronized host inputs, together with an engine-ready flag, are collected into a read-only status byte. The block also drives registered cycle-type, single-cycle, attention and user status outputs.

Top module: `host_cycle_handshake`

## Requirements
- R1: After reset the request pin is at its inactive level for the selected polarity, `word_done` and `abort_irq` are 0, `cyc_type` is 00, and status bit 5 (engine ready) is 1.
- R2: A one-cycle `word_go` pulse, sampled at a clock edge while the engine is idle, makes the request active two edges later. The request stays active until three edges after the busy pin turns active, and then goes inactive.
- R3: Three edges after the busy pin returns inactive at the end of a host cycle, `word_done` is 1 for exactly one cycle.
- R4: The request is never made active while the synchronized busy is active. A word that is pending waits, and its request turns active three edges after busy goes inactive.
- R5: The request pin is active-high when `creq_act_low`=0 and active-low when it is 1. Busy is read as active-high when `busy_act_low`=0 and active-low when it is 1. All four pairings complete a word.
- R6: `cyc_type` is 2'b10 for a memory-to-host word and 2'b00 for a host-to-memory word, taken from `dir_to_host` when the word is accepted. Codes 01 and 11 never appear.
- R7: `single_cyc_n` equals the inverse of `burst`, `attn` equals `abort_req`, and `user_out` equals `user_in`, each one edge after the input.
- R8: `status` carries function codes 1..3 (from `host_fn[0..2]`) in bits 0..2, host init in bit 3, host ready in bit 4 and engine ready (idle with no pending word) in bit 5. Bits 6 and 7 are 0. Host-sourced bits follow their pins two edges later.
- R9: A high level on `host_fn[1]` forces the engine idle and drops the pending word. It also sets `abort_irq`, three edges after the pin rises. `abort_irq` holds until `irq_clr` is pulsed while the synchronized `host_fn[1]` is low, and a clear during the high level has no effect.
- R10: No request is issued while host ready is low. The pending word's request turns active three edges after host ready returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_go | input | 1 | One-cycle pulse from the sequencer: handle one word |
| dir_to_host | input | 1 | Word direction: 1 memory-to-host, 0 host-to-memory |
| burst | input | 1 | Burst transfer selected |
| abort_req | input | 1 | Ask the host to abort the present transfer |
| user_in | input | USER_W | User status values to drive to the host |
| creq_act_low | input | 1 | Request pin polarity: 1 = active low |
| busy_act_low | input | 1 | Busy pin polarity: 1 = active low |
| irq_clr | input | 1 | Clears the abort interrupt flag |
| host_busy | input | 1 | Busy pin from the remote interface |
| host_ready | input | 1 | Host ready pin, active high |
| host_init | input | 1 | Host init pin, active high |
| host_fn | input | FN_W | Host function-code pins 1..3 |
| cyc_req | output | 1 | Cycle request pin to the remote interface |
| cyc_type | output | 2 | Cycle-type code to the host |
| single_cyc_n | output | 1 | Low for burst transfers |
| attn | output | 1 | Attention (abort request) to the host |
| user_out | output | USER_W | User status outputs to the host |
| word_done | output | 1 | One-cycle pulse: host cycle for the word finished |
| abort_irq | output | 1 | Latched abort interrupt flag |
| status | output | 8 | Read-only status byte |

## Verification
The bench drives every input on the falling edge and samples on a falling edge after a counted number of rising edges. Host pins reach the status byte after two rising edges and reach the request, completion flag and interrupt after three, because the state register follows the two synchronizer stages. A `word_go` pulse shows on the request after two edges: one to latch the pending word and one to enter the request state. The pass-through outputs follow after one edge. Each scenario also checks one cycle before the expected change, to show that the value is still the old one, and one cycle after a pulse, to show that the pulse has ended.

// File: rtl/host_cycle_handshake.sv
module host_cycle_handshake #(
  parameter int SYNC_STAGES = 2,
  parameter int FN_W        = 3,
  parameter int USER_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_go,
  input  logic              dir_to_host,
  input  logic              burst,
  input  logic              abort_req,
  input  logic [USER_W-1:0] user_in,
  input  logic              creq_act_low,
  input  logic              busy_act_low,
  input  logic              irq_clr,
  input  logic              host_busy,
  input  logic              host_ready,
  input  logic              host_init,
  input  logic [FN_W-1:0]   host_fn,
  output logic              cyc_req,
  output logic [1:0]        cyc_type,
  output logic              single_cyc_n,
  output logic              attn,
  output logic [USER_W-1:0] user_out,
  output logic              word_done,
  output logic              abort_irq,
  output logic [7:0]        status
);
  localparam int IN_W = FN_W + 3;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;

  logic [IN_W-1:0] sync_q [SYNC_STAGES];
  logic [IN_W-1:0] sync_s;
  logic            busy_act, ready_s, init_s, fn2_s;
  logic [FN_W-1:0] fn_s;
  st_t             st;
  logic            pend, dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= {host_fn, host_init, host_ready, host_busy};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign sync_s   = sync_q[SYNC_STAGES-1];
  assign busy_act = sync_s[0] ^ busy_act_low;
  assign ready_s  = sync_s[1];
  assign init_s   = sync_s[2];
  assign fn_s     = sync_s[3 +: FN_W];
  assign fn2_s    = fn_s[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      pend         <= 1'b0;
      dir_q        <= 1'b0;
      word_done    <= 1'b0;
      abort_irq    <= 1'b0;
      single_cyc_n <= 1'b1;
      attn         <= 1'b0;
      user_out     <= '0;
    end else begin
      word_done    <= 1'b0;
      single_cyc_n <= ~burst;
      attn         <= abort_req;
      user_out     <= user_in;
      if (fn2_s) begin
        abort_irq <= 1'b1;
        pend      <= 1'b0;
        st        <= S_IDLE;
      end else begin
        if (irq_clr) abort_irq <= 1'b0;
        case (st)
          S_IDLE: begin
            if (pend && !busy_act && ready_s) begin
              st   <= S_REQ;
              pend <= 1'b0;
            end else if (word_go && !pend) begin
              pend  <= 1'b1;
              dir_q <= dir_to_host;
            end
          end
          S_REQ:  if (busy_act) st <= S_WAIT;
          S_WAIT: if (!busy_act) begin
            st        <= S_IDLE;
            word_done <= 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign cyc_req  = (st == S_REQ) ^ creq_act_low;
  assign cyc_type = {dir_q, 1'b0};
  assign status   = {2'b00, (st == S_IDLE) && !pend, ready_s, init_s, fn_s};
endmodule

// File: rtl/host_cycle_handshake_chk.sv
module host_cycle_handshake_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cyc_req,
  input logic       creq_act_low,
  input logic       busy_act,
  input logic       fn2_s,
  input logic       word_done,
  input logic       abort_irq,
  input logic [1:0] cyc_type
);
  logic req_act;
  assign req_act = cyc_req ^ creq_act_low;

  p_req_needs_idle_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_act) && $stable(creq_act_low) |-> $past(!busy_act));

  p_req_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_act && !busy_act && !fn2_s && $stable(creq_act_low) |=> req_act);

  p_done_after_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> !req_act && $past(!req_act));

  p_abort_sets_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fn2_s |=> abort_irq);

  p_abort_drops_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fn2_s && $stable(creq_act_low) |=> !req_act);

  p_type_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_type[0] == 1'b0);
endmodule

bind host_cycle_handshake host_cycle_handshake_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_req(cyc_req), .creq_act_low(creq_act_low),
  .busy_act(busy_act), .fn2_s(fn2_s), .word_done(word_done),
  .abort_irq(abort_irq), .cyc_type(cyc_type)
);

// File: tb/tb_host_cycle_handshake.sv
module tb_host_cycle_handshake;
  logic clk = 0, rst_n = 0;
  logic word_go = 0, dir_to_host = 0, burst = 0, abort_req = 0, irq_clr = 0;
  logic [1:0] user_in = 0;
  logic creq_act_low = 0, busy_act_low = 0;
  logic host_busy = 0, host_ready = 1, host_init = 0;
  logic [2:0] host_fn = 0;
  logic cyc_req, single_cyc_n, attn, word_done, abort_irq;
  logic [1:0] cyc_type, user_out;
  logic [7:0] status;
  int checks = 0, fails = 0;

  host_cycle_handshake dut (.*);

  always #4 clk = ~clk;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic req_pin(logic active);
    return active ^ creq_act_low;
  endfunction

  task automatic set_busy(logic active);
    host_busy = active ^ busy_act_low;
  endtask

  task automatic pulse_go(logic dir);
    dir_to_host = dir; word_go = 1; tick(1); word_go = 0;
  endtask

  // request is active now; run the host cycle to completion
  task automatic finish_word(string req);
    set_busy(1); tick(2);
    chk(req, cyc_req, req_pin(1));
    tick(1);
    chk(req, cyc_req, req_pin(0));
    set_busy(0); tick(2);
    chk({req, " R3 early"}, word_done, 0);
    tick(1);
    chk({req, " R3"}, word_done, 1);
    tick(1);
    chk({req, " R3 pulse"}, word_done, 0);
  endtask

  task automatic t_reset;
    chk("R1 req", cyc_req, 0);
    chk("R1 done", word_done, 0);
    chk("R1 irq", abort_irq, 0);
    chk("R1 type", cyc_type, 2'b00);
    chk("R1 rdy", status[5], 1);
  endtask

  task automatic t_basic;
    pulse_go(1); tick(1);
    chk("R2 req up", cyc_req, 1);
    chk("R6 to host", cyc_type, 2'b10);
    chk("R8 busy rdy", status[5], 0);
    finish_word("R2");
    pulse_go(0); tick(1);
    chk("R6 from host", cyc_type, 2'b00);
    finish_word("R2 second");
  endtask

  task automatic t_polarity;
    for (int c = 1; c < 4; c++) begin
      creq_act_low = c[1]; busy_act_low = c[0];
      set_busy(0); tick(4);
      chk("R5 idle level", cyc_req, req_pin(0));
      pulse_go(c[0]); tick(1);
      chk("R5 active level", cyc_req, req_pin(1));
      finish_word("R5");
    end
    creq_act_low = 0; busy_act_low = 0; set_busy(0); tick(4);
  endtask

  task automatic t_busy_block;
    set_busy(1); tick(4);
    pulse_go(1); tick(5);
    chk("R4 held", cyc_req, 0);
    set_busy(0); tick(2);
    chk("R4 early", cyc_req, 0);
    tick(1);
    chk("R4 release", cyc_req, 1);
    finish_word("R4");
  endtask

  task automatic t_ready_block;
    host_ready = 0; tick(3);
    pulse_go(0); tick(5);
    chk("R10 held", cyc_req, 0);
    host_ready = 1; tick(2);
    chk("R10 early", cyc_req, 0);
    tick(1);
    chk("R10 release", cyc_req, 1);
    finish_word("R10");
  endtask

  task automatic t_status;
    host_fn = 3'b101; host_init = 1; host_ready = 0; tick(1);
    chk("R8 early", status, 8'h30);
    tick(1);
    chk("R8 pattern a", status, 8'h2D);
    host_fn = 3'b001; host_init = 0; host_ready = 1; tick(2);
    chk("R8 pattern b", status, 8'h31);
  endtask

  task automatic t_passthru;
    burst = 1; abort_req = 1; user_in = 2'b10; tick(1);
    chk("R7 single", single_cyc_n, 0);
    chk("R7 attn", attn, 1);
    chk("R7 user", user_out, 2'b10);
    burst = 0; abort_req = 0; user_in = 2'b01; tick(1);
    chk("R7 single off", single_cyc_n, 1);
    chk("R7 attn off", attn, 0);
    chk("R7 user b", user_out, 2'b01);
  endtask

  task automatic t_abort;
    pulse_go(1); tick(1);
    chk("R9 req up", cyc_req, 1);
    host_fn = 3'b010; tick(2);
    chk("R9 early", abort_irq, 0);
    tick(1);
    chk("R9 irq", abort_irq, 1);
    chk("R9 req dropped", cyc_req, 0);
    irq_clr = 1; tick(1); irq_clr = 0;
    chk("R9 clear ignored", abort_irq, 1);
    host_fn = 3'b000; tick(3);
    chk("R9 no resume", cyc_req, 0);
    chk("R9 idle rdy", status[5], 1);
    irq_clr = 1; tick(1); irq_clr = 0;
    chk("R9 cleared", abort_irq, 0);
    // abort with a word only pending behind busy
    set_busy(1); tick(3);
    pulse_go(0); tick(1);
    host_fn = 3'b010; tick(3);
    host_fn = 3'b000; set_busy(0); tick(6);
    chk("R9 pending dropped", cyc_req, 0);
    irq_clr = 1; tick(1); irq_clr = 0;
  endtask

  initial begin
    tick(3);
    t_reset();
    rst_n = 1; tick(4);
    t_basic();
    t_polarity();
    t_busy_block();
    t_ready_block();
    t_status();
    t_passthru();
    t_abort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule